// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block is the transmit engine of a descriptor-chained DMA. Software builds a linked list of descriptors in memory, gives the engine the address of the first one and the address of the last one, and raises run. The engine then works through the chain on its own. For each descriptor it reads the fields it needs over a single word-wide memory request port, reads the referenced buffer, and sends its bytes one per beat on an AXI4-Stream master. When the buffer is finished it writes a completion status back into the descriptor and follows the next pointer.

Descriptors are grouped into frames by start and end flags in their control word. A start descriptor supplies six application words, which are held on a sideband output for the whole frame. The last byte of an end descriptor's buffer carries TLAST, and a one-cycle completion pulse follows that descriptor's status write. The engine stops and raises idle after finishing the tail descriptor. It also stops and raises idle when it fetches a descriptor that is already marked complete. Addresses are 32 bits; the upper halves of the 64-bit pointer fields are never read.

Top module: `sgw_tx_walker`

## Requirements
- R1: After synchronous reset, idle_o is 1, and m_tvalid_o, mem_req_o and frame_done_o are 0.
- R2: The engine issues no memory request while run_i is low or idle_o is high. A pulse on tail_load_i loads the tail address and clears idle_o. cur_load_i is taken only while the engine is waiting between descriptors.
- R3: A descriptor is read at byte offsets 0x00 (next pointer), 0x08 (buffer address) and 0x18 (control), then 0x1C (status). Control bits 22:0 give the length in bytes, bit 26 ends a frame and bit 27 starts one. Memory words are little-endian: the byte at address A sits in bits 8*(A mod 4)+7 : 8*(A mod 4) of the word at A with its low two bits cleared.
- R4: A fetched descriptor whose status bit 31 is already set makes the engine set idle_o and stop. It moves no data and writes nothing.
- R5: Buffer bytes leave on m_tdata_o in ascending address order, whatever the buffer's alignment. m_tlast_o is high only on the last byte of a buffer whose end-of-frame bit is set.
- R6: While m_tvalid_o is high and m_tready_i is low, m_tvalid_o, m_tdata_o and m_tlast_o hold their values, and no byte is lost.
- R7: After a buffer is consumed, the word (length | 0x80000000) is written at descriptor + 0x1C. This is the only kind of write the engine makes.
- R8: frame_done_o pulses for exactly one cycle after the status write of each end-of-frame descriptor, and at no other time.
- R9: A start-of-frame descriptor loads its six words from offsets 0x20..0x34 into sideband_o, word i at bits 32*i+31 : 32*i. Other descriptors leave sideband_o unchanged.
- R10: After each descriptor the current pointer takes its next pointer. If the finished descriptor was at the tail address, the engine sets idle_o and touches no further descriptor.
- R11: A zero-length descriptor sends no bytes but still gets its status write (value 0x80000000).
- R12: If run_i falls mid-chain, the current descriptor is completed and the engine then waits with idle_o low. It resumes at the next descriptor when run_i rises again.
- R13: The memory port has at most one request outstanding. mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold until mem_ack_i, which returns read data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Engine enable level |
| cur_load_i | input | 1 | Load current descriptor pointer |
| cur_addr_i | input | 32 | Current descriptor address to load |
| tail_load_i | input | 1 | Load tail pointer and clear idle |
| tail_addr_i | input | 32 | Tail descriptor address |
| idle_o | output | 1 | Chain finished or stopped on a completed descriptor |
| frame_done_o | output | 1 | One-cycle pulse per finished frame |
| sideband_o | output | 192 | Application words of the current frame |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned except for descriptor bases as given |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| m_tvalid_o | output | 1 | Stream byte valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | 8 | Stream byte |
| m_tlast_o | output | 1 | Last byte of frame |

## Verification
On every cycle, the assertions check the handshake rules on both sides. A pending memory request and a stalled stream beat must both hold steady. TLAST must appear only with valid, every write must carry the complete bit, the completion pulse must last a single cycle, and an idle engine must stay quiet. Only the directed scenarios can show that the right bytes arrive in the right order from unaligned buffers. The same holds for status values landing in the right descriptors, zero-length and already-complete descriptors, sideband retention across non-start descriptors, stopping at the tail, and pausing and resuming on run.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W   = 32;
  localparam int EOF_BIT  = 26;
  localparam int SOF_BIT  = 27;
  localparam int DONE_BIT = 31;

  localparam logic [7:0] OFS_NEXT = 8'h00;
  localparam logic [7:0] OFS_BUF  = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_APP  = 8'h20;

  typedef enum logic [2:0] {
    W_IDLE, W_DESC, W_APP, W_BUF, W_DATA, W_STAT, W_NEXT
  } walk_state_e;

  typedef enum logic [1:0] {
    E_IDLE, E_WAIT, E_SEND
  } emit_state_e;

  // descriptor word fetch order: next, buffer, control, status
  function automatic logic [7:0] desc_word_ofs(input logic [1:0] k);
    case (k)
      2'd0:    return OFS_NEXT;
      2'd1:    return OFS_BUF;
      2'd2:    return OFS_CTRL;
      default: return OFS_STAT;
    endcase
  endfunction
endpackage

// File: rtl/sgw_mem_port.sv
module sgw_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          req_q, we_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_q) begin
        if (mem_ack_i) begin
          req_q  <= 1'b0;
          done_q <= 1'b1;
          if (!we_q) rdata_q <= mem_rdata_i;
        end
      end else if (start_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/sgw_byte_emitter.sv
module sgw_byte_emitter
  import sgw_pkg::*;
#(
  parameter int LEN_W  = 23,
  parameter int WORD_W_P = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [LEN_W-1:0]            len_i,
  input  logic [$clog2(WORD_W_P/8)-1:0] lane_i,
  input  logic                        eof_i,
  input  logic                        word_vld_i,
  input  logic [WORD_W_P-1:0]         word_i,
  output logic                        want_o,
  output logic                        buf_done_o,
  output logic                        m_tvalid_o,
  input  logic                        m_tready_i,
  output logic [7:0]                  m_tdata_o,
  output logic                        m_tlast_o
);
  localparam int LANES  = WORD_W_P / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
  localparam logic [LEN_W-1:0]  ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0]  TWO = LEN_W'(2);

  emit_state_e          st;
  logic [LEN_W-1:0]     rem;
  logic [LANE_W-1:0]    lane;
  logic                 eof_q, want_q, bdone_q, tvalid_q, tlast_q;
  logic [WORD_W_P-1:0]  word_q;
  logic [7:0]           tdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      rem      <= '0;
      lane     <= '0;
      eof_q    <= 1'b0;
      want_q   <= 1'b0;
      bdone_q  <= 1'b0;
      tvalid_q <= 1'b0;
      tlast_q  <= 1'b0;
      word_q   <= '0;
      tdata_q  <= '0;
    end else begin
      want_q  <= 1'b0;
      bdone_q <= 1'b0;
      case (st)
        E_IDLE: if (start_i) begin
          rem   <= len_i;
          lane  <= lane_i;
          eof_q <= eof_i;
          st    <= E_WAIT;
        end
        E_WAIT: if (word_vld_i) begin
          word_q   <= word_i;
          tvalid_q <= 1'b1;
          tdata_q  <= word_i[8*int'(lane) +: 8];
          tlast_q  <= eof_q && (rem == ONE);
          st       <= E_SEND;
        end
        E_SEND: if (m_tready_i) begin
          if (rem == ONE) begin
            tvalid_q <= 1'b0;
            tlast_q  <= 1'b0;
            bdone_q  <= 1'b1;
            st       <= E_IDLE;
          end else if (lane == LAST_LANE) begin
            tvalid_q <= 1'b0;
            tlast_q  <= 1'b0;
            lane     <= '0;
            rem      <= rem - ONE;
            want_q   <= 1'b1;
            st       <= E_WAIT;
          end else begin
            lane    <= lane + LANE_W'(1);
            rem     <= rem - ONE;
            tdata_q <= word_q[8*(int'(lane)+1) +: 8];
            tlast_q <= eof_q && (rem == TWO);
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign want_o     = want_q;
  assign buf_done_o = bdone_q;
  assign m_tvalid_o = tvalid_q;
  assign m_tdata_o  = tdata_q;
  assign m_tlast_o  = tlast_q;
endmodule

// File: rtl/sgw_tx_walker.sv
module sgw_tx_walker
  import sgw_pkg::*;
#(
  parameter int LEN_W = 23,
  parameter int APP_N = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_i,
  input  logic                    cur_load_i,
  input  logic [WORD_W-1:0]       cur_addr_i,
  input  logic                    tail_load_i,
  input  logic [WORD_W-1:0]       tail_addr_i,
  output logic                    idle_o,
  output logic                    frame_done_o,
  output logic [APP_N*WORD_W-1:0] sideband_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [WORD_W-1:0]       mem_addr_o,
  output logic [WORD_W-1:0]       mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic                    m_tvalid_o,
  input  logic                    m_tready_i,
  output logic [7:0]              m_tdata_o,
  output logic                    m_tlast_o
);
  localparam int K_W = (APP_N > 4) ? $clog2(APP_N) : 2;
  localparam logic [K_W-1:0] K_DESC_LAST = K_W'(3);
  localparam logic [K_W-1:0] K_APP_LAST  = K_W'(APP_N - 1);
  localparam int PAD_W = WORD_W - 1 - LEN_W;

  walk_state_e       st;
  logic              pend;
  logic [K_W-1:0]    k;
  logic [WORD_W-1:0] cur_q, tail_q, next_q, buf_q, waddr_q;
  logic [LEN_W-1:0]  len_q;
  logic              sof_q, eof_q, idle_q, fdone_q;
  logic [WORD_W-1:0] side_q [APP_N];

  logic              mp_start, mp_we, mp_done;
  logic [WORD_W-1:0] mp_addr, mp_wdata, rd;
  logic              em_start, em_want, em_bdone, em_word_vld;

  always_comb begin
    mp_start = 1'b0;
    mp_we    = 1'b0;
    mp_addr  = cur_q;
    mp_wdata = '0;
    em_start = 1'b0;
    case (st)
      W_DESC: if (!pend) begin
        mp_start = 1'b1;
        mp_addr  = cur_q + WORD_W'(desc_word_ofs(k[1:0]));
      end
      W_APP: if (!pend) begin
        mp_start = 1'b1;
        mp_addr  = cur_q + WORD_W'(OFS_APP) + WORD_W'({k, 2'b00});
      end
      W_BUF: if (len_q != '0) begin
        mp_start = 1'b1;
        mp_addr  = {buf_q[WORD_W-1:2], 2'b00};
        em_start = 1'b1;
      end
      W_DATA: if (em_want) begin
        mp_start = 1'b1;
        mp_addr  = waddr_q + WORD_W'(4);
      end
      W_STAT: if (!pend) begin
        mp_start = 1'b1;
        mp_we    = 1'b1;
        mp_addr  = cur_q + WORD_W'(OFS_STAT);
        mp_wdata = {1'b1, {PAD_W{1'b0}}, len_q};
      end
      default: ;
    endcase
  end

  assign em_word_vld = mp_done && (st == W_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      pend    <= 1'b0;
      k       <= '0;
      cur_q   <= '0;
      tail_q  <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      waddr_q <= '0;
      len_q   <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      idle_q  <= 1'b1;
      fdone_q <= 1'b0;
      for (int i = 0; i < APP_N; i++) side_q[i] <= '0;
    end else begin
      fdone_q <= 1'b0;
      if (mp_done) pend <= 1'b0;
      else if (mp_start) pend <= 1'b1;

      case (st)
        W_IDLE: if (run_i && !idle_q) begin
          st <= W_DESC;
          k  <= '0;
        end
        W_DESC: if (mp_done) begin
          case (k[1:0])
            2'd0: next_q <= rd;
            2'd1: buf_q  <= rd;
            2'd2: begin
              len_q <= rd[LEN_W-1:0];
              eof_q <= rd[EOF_BIT];
              sof_q <= rd[SOF_BIT];
            end
            default: ;
          endcase
          if (k == K_DESC_LAST) begin
            k <= '0;
            if (rd[DONE_BIT]) begin
              idle_q <= 1'b1;
              st     <= W_IDLE;
            end else if (sof_q) begin
              st <= W_APP;
            end else begin
              st <= W_BUF;
            end
          end else begin
            k <= k + K_W'(1);
          end
        end
        W_APP: if (mp_done) begin
          side_q[k] <= rd;
          if (k == K_APP_LAST) begin
            k  <= '0;
            st <= W_BUF;
          end else begin
            k <= k + K_W'(1);
          end
        end
        W_BUF: begin
          if (len_q == '0) st <= W_STAT;
          else begin
            waddr_q <= {buf_q[WORD_W-1:2], 2'b00};
            st      <= W_DATA;
          end
        end
        W_DATA: begin
          if (em_want) waddr_q <= waddr_q + WORD_W'(4);
          if (em_bdone) st <= W_STAT;
        end
        W_STAT: if (mp_done) begin
          if (eof_q) fdone_q <= 1'b1;
          st <= W_NEXT;
        end
        W_NEXT: begin
          cur_q <= next_q;
          if (cur_q == tail_q) idle_q <= 1'b1;
          st <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase

      if (cur_load_i && (st == W_IDLE)) cur_q <= cur_addr_i;
      if (tail_load_i) begin
        tail_q <= tail_addr_i;
        idle_q <= 1'b0;
      end
    end
  end

  sgw_mem_port #(.AW(WORD_W), .DW(WORD_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .start_i     (mp_start),
    .we_i        (mp_we),
    .addr_i      (mp_addr),
    .wdata_i     (mp_wdata),
    .done_o      (mp_done),
    .rdata_o     (rd),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );

  sgw_byte_emitter #(.LEN_W(LEN_W), .WORD_W_P(WORD_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .start_i    (em_start),
    .len_i      (len_q),
    .lane_i     (buf_q[1:0]),
    .eof_i      (eof_q),
    .word_vld_i (em_word_vld),
    .word_i     (rd),
    .want_o     (em_want),
    .buf_done_o (em_bdone),
    .m_tvalid_o (m_tvalid_o),
    .m_tready_i (m_tready_i),
    .m_tdata_o  (m_tdata_o),
    .m_tlast_o  (m_tlast_o)
  );

  for (genvar g = 0; g < APP_N; g++) begin : g_side
    assign sideband_o[g*WORD_W +: WORD_W] = side_q[g];
  end

  assign idle_o       = idle_q;
  assign frame_done_o = fdone_q;
endmodule

// File: rtl/sgw_tx_walker_chk.sv
module sgw_tx_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        idle_o,
  input logic        frame_done_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        m_tvalid_o,
  input logic        m_tready_i,
  input logic [7:0]  m_tdata_o,
  input logic        m_tlast_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R13
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)); // R6
  AST_LAST_QUAL: assert property (@(posedge clk) disable iff (rst)
    m_tlast_o |-> m_tvalid_o); // R5
  AST_WRITE_DONE_BIT: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> mem_wdata_o[31]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> !mem_req_o && !m_tvalid_o); // R2
endmodule

bind sgw_tx_walker sgw_tx_walker_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .idle_o       (idle_o),
  .frame_done_o (frame_done_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i),
  .m_tvalid_o   (m_tvalid_o),
  .m_tready_i   (m_tready_i),
  .m_tdata_o    (m_tdata_o),
  .m_tlast_o    (m_tlast_o)
);

// File: tb/sgw_tx_walker_bench.sv
`timescale 1ns/1ps
module sgw_tx_walker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        run, cur_load, tail_load;
  logic [31:0] cur_addr, tail_addr;
  logic        idle, fdone;
  logic [191:0] side;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tvalid, tready, tlast;
  logic [7:0]  tdata;

  sgw_tx_walker u_sgw_tx_walker (
    .clk(clk), .rst(rst), .run_i(run),
    .cur_load_i(cur_load), .cur_addr_i(cur_addr),
    .tail_load_i(tail_load), .tail_addr_i(tail_addr),
    .idle_o(idle), .frame_done_o(fdone), .sideband_o(side),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tdata_o(tdata), .m_tlast_o(tlast)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] mem [0:1023];
  byte unsigned rx_data[$], exp_data[$];
  bit rx_last[$], exp_last[$];
  int fcount = 0, req_starts = 0;
  bit bp = 0, hold = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 7) & 255);
  endfunction

  function automatic logic [31:0] mk_ctrl(input int len, input bit sof, input bit eof);
    return 32'(len) | (32'(eof) << 26) | (32'(sof) << 27);
  endfunction

  // memory model: ack one cycle after request, data with ack
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      req_starts <= req_starts + 1;
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (!rst && tvalid && tready) begin
      rx_data.push_back(tdata);
      rx_last.push_back(tlast);
    end
    if (!rst && fdone) fcount <= fcount + 1;
  end

  always @(negedge clk) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tready <= hold ? 1'b0 : (bp ? lfsr[0] : 1'b1);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] bufa,
                          input logic [31:0] ctrl, input logic [31:0] stat, input logic [31:0] appb);
    mem[a/4+0] = nxt;  mem[a/4+1] = 0;
    mem[a/4+2] = bufa; mem[a/4+3] = 0;
    mem[a/4+4] = 0;    mem[a/4+5] = 0;
    mem[a/4+6] = ctrl; mem[a/4+7] = stat;
    for (int i = 0; i < 6; i++) mem[a/4+8+i] = appb + 32'(i);
  endtask

  task automatic exp_add(input int bufa, input int len, input bit eof);
    for (int i = 0; i < len; i++) begin
      exp_data.push_back(pat(bufa + i));
      exp_last.push_back(eof && (i == len - 1));
    end
  endtask

  task automatic clear_obs();
    rx_data.delete(); rx_last.delete(); exp_data.delete(); exp_last.delete();
  endtask

  task automatic cmp_stream(input string tag);
    int bad;
    bad = 0;
    checks++;
    if (rx_data.size() != exp_data.size()) bad = 1;
    else foreach (exp_data[i])
      if (rx_data[i] !== exp_data[i] || rx_last[i] !== exp_last[i]) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s stream actual_len=%0d expected_len=%0d", tag, rx_data.size(), exp_data.size());
    end
  endtask

  task automatic go(input logic [31:0] c, input logic [31:0] t);
    @(negedge clk);
    cur_load = 1; cur_addr = c; tail_load = 1; tail_addr = t;
    @(negedge clk);
    cur_load = 0; tail_load = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (!idle && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " idle reached"}, 64'(idle), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 idle after reset", 64'(idle), 64'd1);
    chk("R1 tvalid after reset", 64'(tvalid), 64'd0);
    chk("R1 req after reset", 64'(mem_req), 64'd0);
    chk("R1 frame_done after reset", 64'(fdone), 64'd0);
  endtask

  task automatic t_run_gate();
    int r0, f0;
    clear_obs();
    put_desc(32'h100, 32'h140, 32'h400, mk_ctrl(4, 1, 1), 0, 32'hA000_0000);
    run = 0;
    r0 = req_starts; f0 = fcount;
    go(32'h100, 32'h100);
    repeat (40) @(negedge clk);
    chk("R2 no request with run low", 64'(req_starts - r0), 64'd0);
    run = 1;
    wait_idle("R10 single");
    repeat (4) @(negedge clk);
    exp_add(32'h400, 4, 1);
    cmp_stream("R3 R5 single aligned frame");
    chk("R7 status single", 64'(mem[32'h11C/4]), 64'h8000_0004);
    chk("R8 one frame pulse", 64'(fcount - f0), 64'd1);
    chk("R9 sideband word0", 64'(side[31:0]), 64'hA000_0000);
    chk("R9 sideband word5", 64'(side[191:160]), 64'hA000_0005);
    chk("R13 request count", 64'(req_starts - r0), 64'd12);
    r0 = req_starts;
    repeat (30) @(negedge clk);
    chk("R2 quiet while idle", 64'(req_starts - r0), 64'd0);
  endtask

  task automatic t_chain();
    int f0;
    clear_obs();
    bp = 1;
    put_desc(32'h200, 32'h240, 32'h501, mk_ctrl(3, 1, 0), 0, 32'hB000_0000);
    put_desc(32'h240, 32'h280, 32'h600, mk_ctrl(0, 0, 0), 0, 32'hC000_0000);
    put_desc(32'h280, 32'h2C0, 32'h603, mk_ctrl(9, 0, 1), 0, 32'hD000_0000);
    put_desc(32'h2C0, 32'h200, 32'h620, mk_ctrl(4, 1, 1), 0, 32'hE000_0000);
    f0 = fcount;
    go(32'h200, 32'h280);
    wait_idle("R10 chain");
    repeat (4) @(negedge clk);
    exp_add(32'h501, 3, 0);
    exp_add(32'h603, 9, 1);
    cmp_stream("R5 R6 unaligned chain under backpressure");
    chk("R7 status first", 64'(mem[32'h21C/4]), 64'h8000_0003);
    chk("R11 zero length status", 64'(mem[32'h25C/4]), 64'h8000_0000);
    chk("R7 status last", 64'(mem[32'h29C/4]), 64'h8000_0009);
    chk("R10 beyond tail untouched", 64'(mem[32'h2DC/4]), 64'h0);
    chk("R8 one frame for chain", 64'(fcount - f0), 64'd1);
    chk("R9 sideband kept from start descriptor", 64'(side[63:32]), 64'hB000_0001);
    bp = 0;
  endtask

  task automatic t_stall();
    int n;
    logic [7:0] d0;
    clear_obs();
    hold = 1;
    put_desc(32'h300, 32'h340, 32'h700, mk_ctrl(6, 1, 1), 0, 32'hF000_0000);
    go(32'h300, 32'h300);
    n = 0;
    while (!tvalid && n < 500) begin @(negedge clk); n++; end
    d0 = tdata;
    repeat (15) @(negedge clk);
    chk("R6 valid held under stall", 64'(tvalid), 64'd1);
    chk("R6 data held under stall", 64'(tdata), 64'(d0));
    hold = 0;
    wait_idle("R6 stall");
    repeat (4) @(negedge clk);
    exp_add(32'h700, 6, 1);
    cmp_stream("R6 no byte lost after stall");
  endtask

  task automatic t_done_desc();
    int f0;
    clear_obs();
    put_desc(32'h340, 32'h380, 32'h720, mk_ctrl(2, 1, 1), 0, 32'h1000_0000);
    put_desc(32'h380, 32'h3C0, 32'h740, mk_ctrl(4, 1, 1), 32'h8000_0005, 32'h2000_0000);
    f0 = fcount;
    go(32'h340, 32'h3C0);
    wait_idle("R4 stop");
    repeat (4) @(negedge clk);
    exp_add(32'h720, 2, 1);
    cmp_stream("R4 no data from completed descriptor");
    chk("R4 completed status untouched", 64'(mem[32'h39C/4]), 64'h8000_0005);
    chk("R4 sideband not reloaded", 64'(side[31:0]), 64'h1000_0000);
    chk("R8 frames before stop", 64'(fcount - f0), 64'd1);
  endtask

  task automatic t_pause();
    int n, f0;
    clear_obs();
    put_desc(32'h180, 32'h1C0, 32'h780, mk_ctrl(5, 1, 1), 0, 32'h3000_0000);
    put_desc(32'h1C0, 32'h100, 32'h7A0, mk_ctrl(2, 1, 1), 0, 32'h4000_0000);
    f0 = fcount;
    go(32'h180, 32'h1C0);
    n = 0;
    while (!tvalid && n < 500) begin @(negedge clk); n++; end
    run = 0;
    repeat (100) @(negedge clk);
    chk("R12 current finished", 64'(mem[32'h19C/4]), 64'h8000_0005);
    chk("R12 next not started", 64'(mem[32'h1DC/4]), 64'h0);
    chk("R12 idle low while paused", 64'(idle), 64'd0);
    run = 1;
    wait_idle("R12 resume");
    repeat (4) @(negedge clk);
    chk("R12 next done after resume", 64'(mem[32'h1DC/4]), 64'h8000_0002);
    exp_add(32'h780, 5, 1);
    exp_add(32'h7A0, 2, 1);
    cmp_stream("R5 two frames across pause");
    chk("R8 two frames", 64'(fcount - f0), 64'd2);
  endtask

  initial begin
    run = 0; cur_load = 0; tail_load = 0; cur_addr = 0; tail_addr = 0;
    for (int i = 0; i < 1024; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_run_gate();
    t_chain();
    t_stall();
    t_done_desc();
    t_pause();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule